// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block turns level changes on a set of already-synchronized GPIO pins into interrupt requests. Software chooses, pin by pin, whether a rising edge, a falling edge or both should be noticed. It does this through paired "turn on" and "turn off" mask registers, so no read-modify-write is needed. Every noticed edge sets a sticky status bit. Software acknowledges a status bit by writing a one to that position.

The status word is cut into fixed-size banks of pins. Each bank drives one level-sensitive interrupt line. The line is high while any status bit of that bank is set and the bank's bit in the bank-enable register is one. A handler can therefore read the status, acknowledge what it saw and repeat until the status reads zero. The register port is a plain single-cycle write strobe with a combinational read address and data. It has no handshake, and there is no streaming data path.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the rising-edge mask, falling-edge mask, status word and bank-enable register all read zero, and every `irq_o` bit is low.
- R2: A write to offset 0x14 (rise-on) or 0x1C (fall-on) sets the rising or falling mask bits where the data has ones. Zero data bits leave the mask unchanged. Either mask reads back at its on-offset and at its off-offset.
- R3: A write to offset 0x18 (rise-off) or 0x20 (fall-off) clears the mask bits where the data has ones. Zero data bits have no effect.
- R4: A pin whose rising mask bit is set latches its status bit on the clock edge after its level goes from 0 to 1. A pin with the bit clear latches nothing on that transition.
- R5: A pin whose falling mask bit is set latches its status bit on the clock edge after its level goes from 1 to 0. A pin with the bit clear latches nothing on that transition.
- R6: With both masks set for a pin, each transition in either direction latches its status bit.
- R7: Writing to the status offset 0x24 clears exactly the bits written as one. Zero bits leave their status unchanged.
- R8: An enabled edge in the same cycle as a clear of its status bit leaves the bit set.
- R9: Clearing a mask bit does not clear a status bit that is already latched.
- R10: Status bits 0..15 feed `irq_o[0]` and bits 16..31 feed `irq_o[1]`. A line stays high for as long as any of its bits is set and its bank is enabled.
- R11: The bank-enable register at offset 0x08 holds one bit per bank, with bit n gating `irq_o[n]`. A disabled bank keeps its line low whatever its status.
- R12: Reads at offsets not listed above return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational from `rd_addr` |
| irq_o | output | 2 | Per-bank level interrupt lines |

## Verification
The pins are driven with single-pin rises, single-pin falls and round-trip toggles. These separate the rising mask, the falling mask and the both-edges case. Transitions on pins whose masks are clear show that unmasked edges latch nothing. Edges are placed in both halves of the word, with each bank enabled and disabled in turn, to tell a routing error from a gating error. An edge is also made to land in the very cycle its status bit is being acknowledged, which separates set-wins priority from clear-wins priority.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_BANK_EN  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_RISE_ON  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_RISE_OFF = 8'h18;
  localparam logic [REG_AW-1:0] OFS_FALL_ON  = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_FALL_OFF = 8'h20;
  localparam logic [REG_AW-1:0] OFS_STATUS   = 8'h24;

  typedef enum logic [2:0] {
    MASK_NONE,
    MASK_RISE_SET,
    MASK_RISE_CLR,
    MASK_FALL_SET,
    MASK_FALL_CLR
  } mask_op_e;
endpackage

// File: rtl/gpio_edge_find.sv
module gpio_edge_find #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  // a pin hits when its level moved in a direction it is masked for
  always_comb begin
    hit = (rise_en & lvl & ~prev_q) | (fall_en & ~lvl & prev_q);
  end
endmodule

// File: rtl/gpio_enable_regs.sv
module gpio_enable_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned NB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rise_en,
  output logic [W-1:0]      fall_en,
  output logic [NB-1:0]     bank_en
);
  mask_op_e     op;
  logic [W-1:0] rise_d, fall_d;

  always_comb begin
    op = MASK_NONE;
    if (wr_en) begin
      case (wr_addr)
        OFS_RISE_ON:  op = MASK_RISE_SET;
        OFS_RISE_OFF: op = MASK_RISE_CLR;
        OFS_FALL_ON:  op = MASK_FALL_SET;
        OFS_FALL_OFF: op = MASK_FALL_CLR;
        default:      op = MASK_NONE;
      endcase
    end
  end

  always_comb begin
    rise_d = rise_en;
    fall_d = fall_en;
    case (op)
      MASK_RISE_SET: rise_d = rise_en | wr_data;
      MASK_RISE_CLR: rise_d = rise_en & ~wr_data;
      MASK_FALL_SET: fall_d = fall_en | wr_data;
      MASK_FALL_CLR: fall_d = fall_en & ~wr_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      bank_en <= '0;
    end else begin
      rise_en <= rise_d;
      fall_en <= fall_d;
      if (wr_en && wr_addr == OFS_BANK_EN) bank_en <= wr_data[NB-1:0];
    end
  end
endmodule

// File: rtl/gpio_status_reg.sv
module gpio_status_reg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [W-1:0]      hit,
  output logic [W-1:0]      status
);
  logic [W-1:0] ack;

  always_comb begin
    ack = (wr_en && wr_addr == OFS_STATUS) ? wr_data : '0;
  end

  // a fresh edge outranks an acknowledge landing in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~ack) | hit;
  end
endmodule

// File: rtl/gpio_bank_gate.sv
module gpio_bank_gate #(
  parameter int unsigned W  = 32,
  parameter int unsigned BP = 16,
  parameter int unsigned NB = W / BP
) (
  input  logic [W-1:0]  status,
  input  logic [NB-1:0] bank_en,
  output logic [NB-1:0] irq
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign irq[b] = bank_en[b] & (|status[b*BP +: BP]);
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 32,
  parameter int unsigned BANK_PINS = 16,
  localparam int unsigned NB       = PIN_COUNT / BANK_PINS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_COUNT-1:0] pin_lvl,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [PIN_COUNT-1:0] wr_data,
  input  logic [REG_AW-1:0]    rd_addr,
  output logic [PIN_COUNT-1:0] rd_data,
  output logic [NB-1:0]        irq_o
);
  logic [PIN_COUNT-1:0] rise_en_q, fall_en_q, status_q, edge_hit;
  logic [NB-1:0]        bank_en_q;

  gpio_enable_regs #(.W(PIN_COUNT), .NB(NB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rise_en(rise_en_q), .fall_en(fall_en_q),
    .bank_en(bank_en_q)
  );

  gpio_edge_find #(.W(PIN_COUNT)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .rise_en(rise_en_q),
    .fall_en(fall_en_q), .hit(edge_hit)
  );

  gpio_status_reg #(.W(PIN_COUNT)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hit(edge_hit), .status(status_q)
  );

  gpio_bank_gate #(.W(PIN_COUNT), .BP(BANK_PINS), .NB(NB)) u_gate (
    .status(status_q), .bank_en(bank_en_q), .irq(irq_o)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_BANK_EN:               rd_data[NB-1:0] = bank_en_q;
      OFS_RISE_ON, OFS_RISE_OFF: rd_data = rise_en_q;
      OFS_FALL_ON, OFS_FALL_OFF: rd_data = fall_en_q;
      OFS_STATUS:                rd_data = status_q;
      default:                   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned NB = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic [W-1:0]      wr_data,
  input logic [W-1:0]      status,
  input logic [W-1:0]      rise_en,
  input logic [W-1:0]      fall_en,
  input logic [NB-1:0]     bank_en,
  input logic [W-1:0]      hit,
  input logic [NB-1:0]     irq
);
  // R2: ones written to the rise-on offset are set afterwards
  a_r2_rise_on: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_RISE_ON) |=> ((rise_en & $past(wr_data)) == $past(wr_data)));

  // R3: ones written to the fall-off offset are clear afterwards
  a_r3_fall_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_FALL_OFF) |=> ((fall_en & $past(wr_data)) == '0));

  // R4: a status bit only appears where some edge mask was on
  a_r4_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~($past(rise_en) | $past(fall_en))) == '0);

  // R7: a status bit only drops when written with a one at the status offset
  a_r7_clear_only_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status) &
     ~(($past(wr_en) && $past(wr_addr) == OFS_STATUS) ? $past(wr_data) : '0)) == '0);

  // R8: every hit is present in the status one cycle later, ack or not
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (status & $past(hit)) == $past(hit));

  for (genvar b = 0; b < NB; b++) begin : g_gate
    // R11: a disabled bank keeps its line low
    a_r11_bank_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en[b] |-> !irq[b]);
  end
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.W(PIN_COUNT), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .status(status_q), .rise_en(rise_en_q),
  .fall_en(fall_en_q), .bank_en(bank_en_q), .hit(edge_hit), .irq(irq_o)
);

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_lvl = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq_o;

  always #2 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // scoreboard: kind 0 = register read, kind 1 = irq lines
  int          q_kind[$];
  logic [7:0]  q_addr[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  int          pending = 0;

  // reference state derived from the requirements
  logic [31:0] m_rise = '0, m_fall = '0, m_stat = '0, m_prev = '0;
  logic [1:0]  m_ben = '0;

  task automatic push(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
    q_kind.push_back(kind); q_addr.push_back(a); q_exp.push_back(e); q_tag.push_back(tag);
    pending++;
  endtask

  // one cycle of stimulus: new pin levels plus an optional write
  task automatic step(input logic [31:0] pins, input logic we, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] hit, ack;
    @(posedge clk); #1;
    pin_lvl = pins; wr_en = we; wr_addr = a; wr_data = d;
    hit = (m_rise & pins & ~m_prev) | (m_fall & ~pins & m_prev);
    ack = (we && a == 8'h24) ? d : '0;
    m_stat = (m_stat & ~ack) | hit;
    m_prev = pins;
    if (we) begin
      case (a)
        8'h14: m_rise = m_rise | d;
        8'h18: m_rise = m_rise & ~d;
        8'h1C: m_fall = m_fall | d;
        8'h20: m_fall = m_fall & ~d;
        8'h08: m_ben = d[1:0];
        default: ;
      endcase
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(m_prev, 1'b1, a, d);
  endtask

  task automatic pins(input logic [31:0] v);
    step(v, 1'b0, 8'h00, '0);
  endtask

  task automatic check_all(input string tag);
    push(0, 8'h08, {30'd0, m_ben}, tag);
    push(0, 8'h14, m_rise, tag);
    push(0, 8'h18, m_rise, tag);
    push(0, 8'h1C, m_fall, tag);
    push(0, 8'h20, m_fall, tag);
    push(0, 8'h24, m_stat, tag);
    push(1, 8'h00, {30'd0, m_ben[1] & (|m_stat[31:16]), m_ben[0] & (|m_stat[15:0])}, tag);
    wait (pending == 0);
  endtask

  // monitor: pops expected items and compares away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      while (q_kind.size() > 0) begin
        int k; logic [7:0] a; logic [31:0] e; string t; logic [31:0] got;
        k = q_kind.pop_front(); a = q_addr.pop_front();
        e = q_exp.pop_front(); t = q_tag.pop_front();
        if (k == 0) begin
          rd_addr = a; #0.1; got = rd_data;
        end else begin
          #0.1; got = {30'd0, irq_o};
        end
        total++;
        if (got !== e) begin
          bad++;
          $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h", t, k, a, got, e);
        end
        pending--;
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R1 reset state");

    wr(8'h14, 32'h0000_00F1);
    check_all("R2 rise-on sets mask");
    wr(8'h14, 32'h0);
    check_all("R2 zero bits no effect");
    wr(8'h1C, 32'h0001_0000);
    check_all("R2 fall-on sets mask");

    pins(32'h0000_0101);            // bit0 masked rise, bit8 not masked
    check_all("R4 rising edge latches, unmasked pin ignored");
    check_all("R11 bank disabled keeps line low");
    wr(8'h08, 32'h1);
    check_all("R11 bank0 enabled drives line");
    check_all("R10 low half feeds line 0");

    pins(32'h0001_0101);            // bit16 rises, only falling mask
    check_all("R5 rise on fall-only pin ignored");
    pins(32'h0000_0101);            // bit16 falls
    check_all("R5 falling edge latches");
    wr(8'h08, 32'h2);
    check_all("R10 high half feeds line 1, bank0 gated");
    wr(8'h08, 32'h3);
    check_all("R11 both banks enabled");

    pins(32'h0000_0001);            // bit8 falls, no falling mask
    check_all("R5 unmasked fall ignored");

    wr(8'h14, 32'h0010_0000);
    wr(8'h1C, 32'h0010_0000);
    wr(8'h24, 32'h0001_0000);
    check_all("R7 clear bit16");
    pins(32'h0010_0001);
    check_all("R6 both masks, rise latches");
    wr(8'h24, 32'h0010_0000);
    pins(32'h0000_0001);
    check_all("R6 both masks, fall latches");

    wr(8'h24, 32'h0);
    check_all("R7 zero write leaves status");
    wr(8'h24, 32'h0000_0001);
    check_all("R7 clear bit0 drops line 0");

    pins(32'h0000_0011);            // bit4 rises
    wr(8'h18, 32'h0000_0010);
    check_all("R9 mask clear keeps status bit4");
    wr(8'h18, 32'h0);
    check_all("R3 zero off-bits no effect");
    wr(8'h20, 32'h0010_0000);
    check_all("R3 fall-off clears mask");

    wr(8'h24, 32'h0010_0010);
    check_all("R7 clear bits 4 and 20");
    step(32'h0010_0011, 1'b1, 8'h24, 32'h0010_0000); // bit20 rises as it is acked
    check_all("R8 edge beats same-cycle clear");
    wr(8'h24, 32'hFFFF_FFFF);
    check_all("R7 clear all");

    push(0, 8'h00, 32'h0, "R12 unmapped 0x00");
    push(0, 8'h04, 32'h0, "R12 unmapped 0x04");
    push(0, 8'h28, 32'h0, "R12 unmapped 0x28");
    wait (pending == 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule